// File: doc/BRIEF.md
# Event Capture Unit with Software Trigger

The block takes a snapshot of an externally supplied 12-bit counter value whenever a qualifying event arrives. Hardware events come from either a pin event line (source A) or a comparator event line (source B). A static select input picks which of the two may capture, and an enable input gates them. Software can force a snapshot at any time by writing a trigger bit. The block remembers whether the last snapshot came from software or from hardware and reports this in the same bit position on read-back.

Software sees the block through four 8-bit registers. The 12-bit snapshot is split into a low byte and a high byte. Reading the low byte copies the matching high byte into a shared holding byte. A later read of the high byte returns that copy, so a new snapshot that lands between the two reads cannot mix two values. An interrupt-enable register holds one enable per hardware source. A flag register holds one sticky request per source, and each flag is cleared by writing 1 to it. The interrupt output is high while any flag is set.

Top module: `evcap_top`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is low.
- R2: With `cap_en` high, a one-cycle pulse on the selected event line (`src_sel`=0 pin, 1 comparator) loads `cnt_val` into the snapshot at that clock edge. Address 0 returns snapshot bits 7:0. Address 1, after a read of address 0, returns bits 11:8 in its bits 3:0.
- R3: A pulse on the unselected event line, or any hardware pulse while `cap_en` is low, leaves the snapshot unchanged.
- R4: A write to address 1 with data bit 7 set takes a snapshot of `cnt_val` whatever `cap_en` is. A write to address 1 with bit 7 clear takes no snapshot.
- R5: Bit 7 of the high-byte read is 1 when the last snapshot came from software and 0 when it came from hardware. A software trigger and a hardware event in the same cycle give a single snapshot with bit 7 set to 1.
- R6: A read of address 0 copies {source bit, 000, bits 11:8} into the holding byte at that edge. Address 1 returns the holding byte, even if a newer snapshot has been taken since.
- R7: Bits 6:4 of the high-byte read are always 0.
- R8: Address 2 is the enable register. Bit 3 enables source A (pin) and bit 4 enables source B (comparator). They are writable, and bits 7:5 and 2:0 read 0.
- R9: A hardware event that takes a snapshot sets flag bit 3 (source A) or bit 4 (source B) of address 3 when that source's enable is set. A software snapshot sets no flag. `irq` is high while any flag is set.
- R10: Writing 1 to a flag bit at address 3 clears it. Writing 0 leaves it unchanged. A setting event in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 12 | Free-running counter value to snapshot |
| pin_evt | input | 1 | Pin event pulse (source A) |
| cmp_evt | input | 1 | Comparator event pulse (source B) |
| src_sel | input | 1 | Hardware capture source: 0 pin, 1 comparator |
| cap_en | input | 1 | Enables hardware-triggered snapshots |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 enables, 3 flags |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the holding-byte side effect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The bound checker checks on every cycle that a qualified hardware or software event loads the counter and that anything else leaves the snapshot alone. It also checks the source bit after software and after pure hardware captures, the zero padding in the high byte and the enable register, that the high byte read after a low-byte read matches the earlier snapshot, and how flags set and clear. The bench scenarios show the reset values, the actual byte values seen through the bus, an interleaved capture between the two byte reads, and the collision of a software trigger with a hardware event. They also cover a clear colliding with a new event and the silence of disabled sources.

// File: rtl/evcap_pkg.sv
// Package: shared constants and types for the event capture unit.
// Assumes an 8-bit register bus and a 2-bit register address.
package evcap_pkg;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned SW_BIT  = 7;   // trigger / source bit in high byte
    localparam int unsigned EN_LSB  = 3;   // first per-source bit in enable/flag regs

    typedef enum logic [ADDR_W-1:0] {
        RA_CAP_LO = 2'd0,
        RA_CAP_HI = 2'd1,
        RA_IEN    = 2'd2,
        RA_IFLAG  = 2'd3
    } reg_addr_e;

    // Qualified trigger bundle passed from qualification to storage
    typedef struct packed {
        logic fire;    // any snapshot this cycle
        logic sw;      // software trigger present
        logic hit_a;   // qualified hardware event, pin source
        logic hit_b;   // qualified hardware event, comparator source
    } trig_t;
endpackage

// File: rtl/evcap_trig.sv
// Module: evcap_trig
// Qualifies hardware event pulses against the source select and enable
// and merges in the software trigger. Purely combinational.
// Assumes event inputs are already single-cycle pulses.
module evcap_trig
    import evcap_pkg::*;
(
    input  logic  pin_evt,
    input  logic  cmp_evt,
    input  logic  src_sel,
    input  logic  cap_en,
    input  logic  sw_req,
    output trig_t trig
);
    // Purpose: build the qualified trigger bundle
    always_comb begin
        trig.hit_a = cap_en & ~src_sel & pin_evt;
        trig.hit_b = cap_en &  src_sel & cmp_evt;
        trig.sw    = sw_req;
        trig.fire  = sw_req | trig.hit_a | trig.hit_b;
    end
endmodule

// File: rtl/evcap_store.sv
// Module: evcap_store
// Holds the counter snapshot, the software/hardware source bit and the
// holding byte used for tear-free high-byte reads.
// Assumes CNT_W > BUS_W and CNT_W - BUS_W < BUS_W (room for source bit).
module evcap_store
    import evcap_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trig_t            trig,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             lo_rd,
    output logic [CNT_W-1:0] cap_q,
    output logic             src_sw_q,
    output logic [BUS_W-1:0] hold_q
);
    localparam int unsigned HI_W  = CNT_W - BUS_W;
    localparam int unsigned PAD_W = BUS_W - 1 - HI_W;

    // Purpose: take a snapshot and record its source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q    <= '0;
            src_sw_q <= 1'b0;
        end else if (trig.fire) begin
            cap_q    <= cnt_val;
            src_sw_q <= trig.sw;
        end
    end

    // Purpose: copy the high byte into the holding byte on a low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (lo_rd) begin
            hold_q <= {src_sw_q, {PAD_W{1'b0}}, cap_q[CNT_W-1:BUS_W]};
        end
    end
endmodule

// File: rtl/evcap_irq.sv
// Module: evcap_irq
// Per-source interrupt enable bits and sticky request flags.
// A flag is set by a qualified hardware event whose enable is set and
// cleared by a write of 1; a simultaneous set wins over the clear.
module evcap_irq #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hit,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_wdata,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] flag_q,
    output logic            irq
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Purpose: hold the enable bit of source i
        always_ff @(posedge clk) begin
            if (!rst_n)     en_q[i] <= 1'b0;
            else if (en_we) en_q[i] <= en_wdata[i];
        end

        // Purpose: sticky flag of source i, set beats clear
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= (flag_q[i] & ~(clr_we & clr_wdata[i]))
                                     | (hit[i] & en_q[i]);
        end
    end

    // Purpose: combine flags into the request line
    assign irq = |flag_q;
endmodule

// File: rtl/evcap_top.sv
// Module: evcap_top
// Event capture unit: snapshots cnt_val on qualified hardware events or a
// software trigger and presents it on an 8-bit register bus.
// Assumes read data is used in the cycle bus_rd is high.
module evcap_top
    import evcap_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned BUS_W = 8,
    parameter int unsigned NSRC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              pin_evt,
    input  logic              cmp_evt,
    input  logic              src_sel,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam logic [BUS_W-1:0] USED_WD =
        (BUS_W'(1) << SW_BIT) | (BUS_W'((1 << NSRC) - 1) << EN_LSB);

    trig_t            trig;
    logic             sw_req;
    logic             lo_rd;
    logic [CNT_W-1:0] cap_q;
    logic             src_sw_q;
    logic [BUS_W-1:0] hold_q;
    logic [NSRC-1:0]  hit;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  flag_q;
    logic             unused_wdata;

    // Purpose: decode bus strobes into trigger and read side effects
    always_comb begin
        sw_req = bus_wr && (reg_addr_e'(bus_addr) == RA_CAP_HI) && bus_wdata[SW_BIT];
        lo_rd  = bus_rd && (reg_addr_e'(bus_addr) == RA_CAP_LO);
    end

    assign unused_wdata = ^(bus_wdata & ~USED_WD);
    assign hit = NSRC'({trig.hit_b, trig.hit_a});

    evcap_trig u_trig (
        .pin_evt (pin_evt),
        .cmp_evt (cmp_evt),
        .src_sel (src_sel),
        .cap_en  (cap_en),
        .sw_req  (sw_req),
        .trig    (trig)
    );

    evcap_store #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .cnt_val  (cnt_val),
        .lo_rd    (lo_rd),
        .cap_q    (cap_q),
        .src_sw_q (src_sw_q),
        .hold_q   (hold_q)
    );

    evcap_irq #(.NSRC(NSRC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .en_we     (bus_wr && (reg_addr_e'(bus_addr) == RA_IEN)),
        .en_wdata  (bus_wdata[EN_LSB +: NSRC]),
        .clr_we    (bus_wr && (reg_addr_e'(bus_addr) == RA_IFLAG)),
        .clr_wdata (bus_wdata[EN_LSB +: NSRC]),
        .en_q      (mask_q),
        .flag_q    (flag_q),
        .irq       (irq)
    );

    // Purpose: read multiplexer for the four registers
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            RA_CAP_LO: bus_rdata = cap_q[BUS_W-1:0];
            RA_CAP_HI: bus_rdata = hold_q;
            RA_IEN:    bus_rdata[EN_LSB +: NSRC] = mask_q;
            RA_IFLAG:  bus_rdata[EN_LSB +: NSRC] = flag_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evcap_chk.sv
// Module: evcap_chk
// Assertion checker for evcap_top, attached by bind. Observes ports and
// the snapshot, source bit, enable and flag state of the top module.
module evcap_chk #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned BUS_W = 8,
    parameter int unsigned NSRC  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             pin_evt,
    input logic             cmp_evt,
    input logic             src_sel,
    input logic             cap_en,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             irq,
    input logic [CNT_W-1:0] cap_q,
    input logic             src_sw_q,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  flag_q
);
    logic sw, hw, ev_a, ev_b;
    always_comb begin
        sw   = bus_wr && bus_addr == 2'd1 && bus_wdata[7];
        ev_a = cap_en && !src_sel && pin_evt;
        ev_b = cap_en &&  src_sel && cmp_evt;
        hw   = ev_a || ev_b;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hw |=> cap_q == $past(cnt_val));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw && !sw) |=> ($stable(cap_q) && $stable(src_sw_q)));
    p_sw_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw |=> (cap_q == $past(cnt_val)) && src_sw_q);
    p_hw_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw && !sw) |=> !src_sw_q);
    p_hold_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |=>
            (bus_addr != 2'd1 || bus_rdata[CNT_W-BUS_W-1:0] == $past(cap_q[CNT_W-1:BUS_W])));
    p_hi_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd1 |-> bus_rdata[BUS_W-2:CNT_W-BUS_W] == '0);
    p_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd2 |-> (bus_rdata[7:5] == 3'b0 && bus_rdata[2:0] == 3'b0));
    p_set_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_a && mask_q[0]) |=> (flag_q[0] && irq));
    p_set_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_b && mask_q[1]) |=> (flag_q[1] && irq));
    p_clr_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && bus_wdata[3] && !(ev_a && mask_q[0])) |=> !flag_q[0]);
    p_clr_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && bus_wdata[4] && !(ev_b && mask_q[1])) |=> !flag_q[1]);
endmodule

bind evcap_top evcap_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W), .NSRC(NSRC)) u_chk (.*);

// File: tb/evcap_top_test.sv
module evcap_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] cnt_val;
    logic        pin_evt, cmp_evt, src_sel, cap_en;
    logic [1:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    evcap_top uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .pin_evt(pin_evt),
        .cmp_evt(cmp_evt), .src_sel(src_sel), .cap_en(cap_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: compares read data against the scoreboard mid-cycle
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0; pin_evt = 0; cmp_evt = 0;
    endtask

    task automatic apply(input bit wr, input logic [1:0] a, input logic [7:0] d,
                         input bit pin, input bit cmp, input logic [11:0] cnt);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        pin_evt = pin; cmp_evt = cmp; cnt_val = cnt;
        tick();
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_rd = 1; bus_addr = a;
        tick();
    endtask

    task automatic chk_irq(input bit e, input string t);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cnt_val = 0; pin_evt = 0; cmp_evt = 0; src_sel = 0; cap_en = 0;
        bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(2'd0, 8'h00, "R1 low byte");
        rd(2'd1, 8'h00, "R1 high byte");
        rd(2'd2, 8'h00, "R1 enables");
        rd(2'd3, 8'h00, "R1 flags");
        chk_irq(1'b0, "R1 irq");

        // R8 enable register, reserved bits
        apply(1, 2'd2, 8'hFF, 0, 0, 12'h000);
        rd(2'd2, 8'h18, "R8 enable readback");

        // R2 pin capture, R9 source A flag
        cap_en = 1; src_sel = 0;
        apply(0, 2'd0, 8'h00, 1, 0, 12'hABC);
        rd(2'd0, 8'hBC, "R2 low byte pin");
        rd(2'd1, 8'h0A, "R2 R5 R7 high byte pin");
        rd(2'd3, 8'h08, "R9 flag A");
        chk_irq(1'b1, "R9 irq set");

        // R10 clear
        apply(1, 2'd3, 8'h08, 0, 0, 12'hABC);
        rd(2'd3, 8'h00, "R10 flag cleared");
        chk_irq(1'b0, "R10 irq cleared");

        // R3 unselected line and disabled capture
        apply(0, 2'd0, 8'h00, 0, 1, 12'h123);
        rd(2'd0, 8'hBC, "R3 unselected line ignored");
        cap_en = 0;
        apply(0, 2'd0, 8'h00, 1, 0, 12'h456);
        rd(2'd0, 8'hBC, "R3 disabled capture ignored");
        rd(2'd3, 8'h00, "R3 no flag when ignored");

        // R4 software trigger with cap_en low, R5 source bit
        apply(1, 2'd1, 8'h80, 0, 0, 12'h7E5);
        rd(2'd0, 8'hE5, "R4 sw low byte");
        rd(2'd1, 8'h87, "R4 R5 sw high byte");
        rd(2'd3, 8'h00, "R9 sw sets no flag");
        apply(1, 2'd1, 8'h00, 0, 0, 12'h111);
        rd(2'd0, 8'hE5, "R4 bit7 clear no capture");

        // R2 comparator capture, R9 source B
        cap_en = 1; src_sel = 1;
        apply(0, 2'd0, 8'h00, 0, 1, 12'h3C0);
        rd(2'd0, 8'hC0, "R2 low byte cmp");
        rd(2'd1, 8'h03, "R2 R5 high byte cmp");
        rd(2'd3, 8'h10, "R9 flag B");

        // R5 collision of software and hardware
        apply(1, 2'd1, 8'h80, 0, 1, 12'h5A5);
        rd(2'd0, 8'hA5, "R5 collision low byte");
        rd(2'd1, 8'h85, "R5 collision source sw");

        // R10 clear colliding with event
        apply(1, 2'd3, 8'h10, 0, 1, 12'h222);
        rd(2'd3, 8'h10, "R10 set wins over clear");
        apply(1, 2'd3, 8'h00, 0, 0, 12'h222);
        rd(2'd3, 8'h10, "R10 write 0 keeps flag");
        apply(1, 2'd3, 8'h10, 0, 0, 12'h222);
        rd(2'd3, 8'h00, "R10 clear B");

        // R6 capture between the two byte reads
        apply(0, 2'd0, 8'h00, 0, 1, 12'h9F1);
        rd(2'd0, 8'hF1, "R6 first low");
        apply(0, 2'd0, 8'h00, 0, 1, 12'h2E7);
        rd(2'd1, 8'h09, "R6 high holds older snapshot");
        rd(2'd0, 8'hE7, "R6 second low");
        rd(2'd1, 8'h02, "R6 second high");

        // R9 disabled source sets no flag
        apply(1, 2'd3, 8'h18, 0, 0, 12'h000);
        apply(1, 2'd2, 8'h00, 0, 0, 12'h000);
        apply(0, 2'd0, 8'h00, 0, 1, 12'h444);
        rd(2'd3, 8'h00, "R9 masked source no flag");
        chk_irq(1'b0, "R9 masked irq low");

        repeat (2) @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule